// File: doc/BRIEF.md
# Phase/Frequency Detector with Glitch-Free Pump Settings

This block compares two pulse trains that come from a frequency synthesizer: one from the reference divider and one from the main (feedback) divider. A rising edge on one input that arrives before the matching edge on the other input starts a correction pulse. A leading reference edge raises the source command. A leading divider edge raises the sink command. Once both commands are high, the detector holds them together for a fixed short overlap, then clears both in the same cycle, so that very small phase errors still produce a response. The two commands drive an external charge pump whose current sources are not part of this block.

The block also owns the pump settings: a two-bit current-magnitude code and a pump-off bit. Software writes both through a bus register. A write strobe marks the end of a bus transfer and places the new setting into a pending slot. The pending setting is committed only on a clock edge where no correction pulse is active, so the loop filter never sees a current step partway through a pulse. A busy flag equal to source OR sink is exported, so that the divider-ratio update logic can use the same quiet window.

Top module: `pfd_pump_ctl`

## Requirements
- R1: A rising edge on `ref_pulse` sampled at a clock edge while the pump is on raises `pump_up` after that edge. It stays high until cleared by R3 or by turning the pump off.
- R2: A rising edge on `div_pulse` sampled at a clock edge while the pump is on raises `pump_dn` after that edge. It stays high until cleared by R3 or by turning the pump off.
- R3: Once `pump_up` and `pump_dn` are both high, they stay high together for exactly RST_DLY cycles and then fall in the same cycle.
- R4: While `pump_off` is 1, `pump_up` and `pump_dn` are both 0, and input edges seen in that time start no pulse.
- R5: `cfg_wr` = 1 at a clock edge captures `cfg_cur` (the magnitude index 0..3, with 3 the largest current) and `cfg_off` (1 = pump off) as pending. The pending setting appears on `cur_code` and `pump_off` at the first later clock edge at which `busy` is 0.
- R6: `cur_code` and `pump_off` do not change on a clock edge at which `busy` was 1.
- R7: `busy` equals `pump_up` OR `pump_dn` in every cycle.
- R8: Synchronous reset sets `pump_up` and `pump_dn` to 0, `pump_off` to 1 and `cur_code` to 0, and discards any pending setting.
- R9: If several writes arrive while a pulse is active, only the last one is committed.
- R10: An input held high produces no new pulse once the previous pulse is cleared. Only a fresh rising edge starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Output of the reference divider |
| div_pulse | input | 1 | Output of the main divider |
| cfg_wr | input | 1 | Strobe marking a completed bus transfer of the pump setting |
| cfg_cur | input | CUR_W | Requested current-magnitude index |
| cfg_off | input | 1 | Requested pump-off bit |
| pump_up | output | 1 | Source command to the charge pump |
| pump_dn | output | 1 | Sink command to the charge pump |
| cur_code | output | CUR_W | Current-magnitude index now in force |
| pump_off | output | 1 | Pump-off bit now in force |
| busy | output | 1 | High while a source or sink command is active |

## Verification
The bench builds the block with RST_DLY = 3 and CUR_W = 2. With an overlap of three cycles, an off-by-one error in the overlap counter shows up at the ports as a wrong clear cycle, which would stay hidden with a delay of one. The longer overlap also keeps busy high long enough to stack two bus writes inside a single pulse. All four current codes are reached, along with pump-off commits that coincide with an input edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SRC  = 2'd1,
    PH_SNK  = 2'd2,
    PH_CLR  = 2'd3
  } pfd_phase_e;

  localparam int unsigned NUM_IN = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_DIV = 1;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sig_in;
  end

  assign rise = sig_in & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned RST_DLY = 2,
  localparam int unsigned CNT_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic div_rise,
  input  logic hold_off,
  output logic up,
  output logic dn
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_DLY - 1);

  pfd_phase_e ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = '0;
    if (hold_off) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (ref_rise && div_rise) ph_d = PH_CLR;
          else if (ref_rise)        ph_d = PH_SRC;
          else if (div_rise)        ph_d = PH_SNK;
        end
        PH_SRC: if (div_rise) ph_d = PH_CLR;
        PH_SNK: if (ref_rise) ph_d = PH_CLR;
        PH_CLR: begin
          if (cnt_q == LAST) ph_d = PH_IDLE;
          else               cnt_d = cnt_q + 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign up = (ph_q == PH_SRC) || (ph_q == PH_CLR);
  assign dn = (ph_q == PH_SNK) || (ph_q == PH_CLR);
endmodule

// File: rtl/pfd_cfg_sync.sv
module pfd_cfg_sync #(
  parameter int unsigned CUR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CUR_W-1:0] wr_cur,
  input  logic             wr_off,
  input  logic             busy,
  output logic [CUR_W-1:0] cur,
  output logic             off,
  output logic             off_nxt
);
  logic             pend_vld;
  logic [CUR_W-1:0] pend_cur;
  logic             pend_off;
  logic             commit;

  assign commit  = pend_vld & ~busy & ~wr;
  assign off_nxt = commit ? pend_off : off;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_cur <= '0;
      pend_off <= 1'b1;
      cur      <= '0;
      off      <= 1'b1;
    end else begin
      if (wr) begin
        pend_vld <= 1'b1;
        pend_cur <= wr_cur;
        pend_off <= wr_off;
      end else if (commit) begin
        pend_vld <= 1'b0;
      end
      if (commit) begin
        cur <= pend_cur;
        off <= pend_off;
      end
    end
  end
endmodule

// File: rtl/pfd_pump_ctl.sv
module pfd_pump_ctl
  import pfd_pkg::*;
#(
  parameter int unsigned CUR_W   = 2,
  parameter int unsigned RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             div_pulse,
  input  logic             cfg_wr,
  input  logic [CUR_W-1:0] cfg_cur,
  input  logic             cfg_off,
  output logic             pump_up,
  output logic             pump_dn,
  output logic [CUR_W-1:0] cur_code,
  output logic             pump_off,
  output logic             busy
);
  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise;
  logic              off_nxt;

  assign raw_in[IDX_REF] = ref_pulse;
  assign raw_in[IDX_DIV] = div_pulse;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
    pfd_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .sig_in (raw_in[g]),
      .rise   (rise[g])
    );
  end

  pfd_core #(.RST_DLY(RST_DLY)) u_core (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[IDX_REF]),
    .div_rise (rise[IDX_DIV]),
    .hold_off (off_nxt),
    .up       (pump_up),
    .dn       (pump_dn)
  );

  assign busy = pump_up | pump_dn;

  pfd_cfg_sync #(.CUR_W(CUR_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .wr_cur  (cfg_cur),
    .wr_off  (cfg_off),
    .busy    (busy),
    .cur     (cur_code),
    .off     (pump_off),
    .off_nxt (off_nxt)
  );
endmodule

// File: rtl/pfd_pump_ctl_chk.sv
module pfd_pump_ctl_chk #(
  parameter int unsigned CUR_W   = 2,
  parameter int unsigned RST_DLY = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_pulse,
  input logic             div_pulse,
  input logic             pump_up,
  input logic             pump_dn,
  input logic [CUR_W-1:0] cur_code,
  input logic             pump_off,
  input logic             busy
);
  localparam int unsigned OV_W = $clog2(RST_DLY + 2) + 1;
  localparam logic [OV_W-1:0] OV_MAX = {OV_W{1'b1}};
  logic [OV_W-1:0] ov_cnt;

  always_ff @(posedge clk) begin
    if (rst)                                      ov_cnt <= '0;
    else if (pump_up && pump_dn && ov_cnt != OV_MAX) ov_cnt <= ov_cnt + 1'b1;
    else if (!(pump_up && pump_dn))               ov_cnt <= '0;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    pump_off |-> (!pump_up && !pump_dn)); // R4
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cur_code) && $stable(pump_off))); // R6
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (pump_up && pump_dn) |=> (pump_up == pump_dn)); // R3
  AST_OVERLAP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (pump_up && pump_dn) |-> (ov_cnt < OV_W'(RST_DLY))); // R3
  AST_BUSY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    busy == (pump_up || pump_dn)); // R7
  AST_UP_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(ref_pulse)); // R1
  AST_DN_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_dn) |-> $past(div_pulse)); // R2
endmodule

bind pfd_pump_ctl pfd_pump_ctl_chk #(.CUR_W(CUR_W), .RST_DLY(RST_DLY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_pulse (ref_pulse),
  .div_pulse (div_pulse),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .cur_code  (cur_code),
  .pump_off  (pump_off),
  .busy      (busy)
);

// File: tb/test_pfd_pump_ctl.sv
module test_pfd_pump_ctl;
  localparam int unsigned CUR_W   = 2;
  localparam int unsigned RST_DLY = 3;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0, div_pulse = 1'b0, cfg_wr = 1'b0, cfg_off = 1'b0;
  logic [CUR_W-1:0] cfg_cur = '0;
  logic pump_up, pump_dn, pump_off, busy;
  logic [CUR_W-1:0] cur_code;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pfd_pump_ctl #(.CUR_W(CUR_W), .RST_DLY(RST_DLY)) i_pfd_pump_ctl (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .cfg_wr(cfg_wr), .cfg_cur(cfg_cur), .cfg_off(cfg_off),
    .pump_up(pump_up), .pump_dn(pump_dn), .cur_code(cur_code),
    .pump_off(pump_off), .busy(busy));

  // {ref, div, wr, cur[1:0], off} -> {up, dn, cur[1:0], off} after one edge
  localparam logic [10:0] VEC [NV] = '{
    11'b001_10_0_00_00_1, // R5 write cur=2, on
    11'b000_00_0_00_10_0, // R5 committed while idle
    11'b100_00_0_10_10_0, // R1 ref edge
    11'b100_00_0_10_10_0, // R1 held
    11'b010_00_0_11_10_0, // R3 overlap 1
    11'b010_00_0_11_10_0, // R3 overlap 2
    11'b000_00_0_11_10_0, // R3 overlap 3
    11'b000_00_0_00_10_0, // R3 cleared together
    11'b011_01_0_01_10_0, // R2 div edge + write cur=1
    11'b110_00_0_11_10_0, // R6 overlap 1
    11'b110_00_0_11_10_0, // R6 overlap 2
    11'b110_00_0_11_10_0, // R6 overlap 3
    11'b110_00_0_00_10_0, // R6 cleared, not yet committed
    11'b110_00_0_00_01_0, // R10 held inputs, R5 commit
    11'b000_00_0_00_01_0,
    11'b001_11_1_00_01_0, // R4 write off, cur=3
    11'b100_00_0_00_11_1, // R4 commit wins over ref edge
    11'b010_00_0_00_11_1, // R4 div edge ignored
    11'b001_00_0_00_11_1, // R5 write on, cur=0
    11'b000_00_0_00_00_0, // R5 committed
    11'b100_00_0_10_00_0  // R1 works again
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {3'b000, pump_up, pump_dn, cur_code, pump_off};
  endfunction

  task automatic drive(input logic r, input logic d, input logic w,
                       input logic [1:0] c, input logic o);
    ref_pulse = r; div_pulse = d; cfg_wr = w; cfg_cur = c; cfg_off = o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    chk("R8 reset state", outs(), 8'b0000_0001);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:6], VEC[i][5]);
      tick();
      chk($sformatf("R1-5 vec%0d", i), outs(), {3'b000, VEC[i][4:0]});
      chk("R7 busy", {7'b0, busy}, {7'b0, VEC[i][4] | VEC[i][3]});
    end
    // R9: two writes during one pulse, last one wins
    drive(0, 0, 1, 2'b01, 0); tick();
    chk("R9 hold first write", outs(), 8'b0001_0000);
    drive(0, 0, 1, 2'b11, 0); tick();
    chk("R9 hold second write", outs(), 8'b0001_0000);
    drive(0, 1, 0, 2'b00, 0); tick();
    chk("R3 overlap start", outs(), 8'b0001_1000);
    drive(0, 0, 0, 2'b00, 0); tick(); tick();
    chk("R3 overlap last", outs(), 8'b0001_1000);
    tick();
    chk("R6 cleared no commit", outs(), 8'b0000_0000);
    tick();
    chk("R9 last write committed", outs(), 8'b0000_0110);
    // R8: reset during a pulse with a pending write
    drive(1, 0, 0, 2'b00, 0); tick();
    chk("R1 pulse before reset", outs(), 8'b0001_0110);
    drive(1, 0, 1, 2'b10, 0); tick();
    rst = 1'b1;
    drive(0, 0, 0, 2'b00, 0); tick(); tick();
    chk("R8 reset mid pulse", outs(), 8'b0000_0001);
    rst = 1'b0;
    tick(); tick();
    chk("R8 pending discarded", outs(), 8'b0000_0001);
    drive(1, 0, 0, 2'b00, 0); tick();
    chk("R4 edge ignored after reset", outs(), 8'b0000_0001);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule